// File: doc/BRIEF.md
# Configurable Sync Pattern Detector

This block monitors a recovered serial bit stream and flags the start of a packet. On every rising edge of the recovered bit clock it takes one new bit into a window. It compares the most recent N bits with a stored start-of-packet word. N is selectable as 8, 16, 24 or 32. When the number of differing bit positions is no larger than a programmed tolerance of 0 to 3, the block emits a one-cycle detect pulse. That pulse is intended for an interrupt line.

The stored word is organised as four bytes, and only the leading N/8 bytes take part in the comparison. Detection needs two enables to be set: one for bit clocking and one for pattern search. Whenever detection is disabled, or a match has just been reported, the window has to be refilled with N fresh bits before the block can fire again. This prevents a stale or partly filled window from producing a match.

Top module: `sync_word_detector`

## Requirements
- R1: A synchronous active-high `rst` clears the window and the fill count, and `det_o` reads 0 in the cycle after a reset edge. After reset, no detection occurs until N bits have been taken in.
- R2: One bit of `sdata` is taken in per rising `clk` edge while detection is active. `len_sel` selects N: 0 = 8 bits, 1 = 16 bits, 2 = 24 bits, 3 = 32 bits.
- R3: The pattern bytes are `pattern[31:24]` (first), `[23:16]`, `[15:8]` and `[7:0]`. `pattern[31]` is compared with the earliest bit of the N-bit window. `pattern[32-N]`, the LSB of the last active byte, is compared with the bit taken in at the current edge.
- R4: `tol_sel` gives the allowed mismatches: 0 = none, 1 = one bit, 2 = two bits, 3 = three bits. A window whose mismatch count is no larger than this value produces a detect.
- R5: A window whose mismatch count exceeds the tolerance produces no detect.
- R6: `det_o` is registered. It is high for exactly one clock, the clock following the edge that took in the window's last bit.
- R7: Detection is active only while both `bitclk_en` and `det_en` are 1. If either is 0 at an edge, no bit is taken in, the fill count is cleared, and `det_o` is 0 in the following cycle.
- R8: After a detect, N new bits must be taken in before the next detect. An identical pattern sent back-to-back is therefore detected again.
- R9: After detection has been inactive for one or more edges, N new bits must be taken in before a detect. A pattern interrupted by a disable is not reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bitclk_en | input | 1 | Bit clocking enable |
| det_en | input | 1 | Pattern search enable |
| sdata | input | 1 | Recovered serial data |
| len_sel | input | 2 | Pattern length select |
| tol_sel | input | 2 | Mismatch tolerance select |
| pattern | input | 32 | Start-of-packet word, four bytes |
| det_o | output | 1 | Registered detect pulse |

## Verification
The bench builds the block with its default parameters: four 8-bit pattern bytes and a 2-bit tolerance. With these settings, all 16 combinations of length and tolerance can be swept in one run. For each combination, the bench injects patterns with 0 to 4 flipped bits, which crosses every tolerance boundary. It also runs back-to-back repeats, patterns cut off by a disable, and bit-reversed patterns. A bit-by-bit model in the bench predicts `det_o` on every clock.

// File: rtl/sdet_pkg.sv
`timescale 1ns/1ps
package sdet_pkg;
  // number of compared bits for a given length select
  function automatic int unsigned active_bits(int unsigned sel, int unsigned byte_w);
    return (sel + 1) * byte_w;
  endfunction
endpackage

// File: rtl/sdet_window.sv
`timescale 1ns/1ps
module sdet_window #(
  parameter int PAT_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             clear_fill,
  input  logic             bit_i,
  output logic [PAT_W-1:0] next_win_o,
  output logic [CNT_W-1:0] fill_o
);
  logic [PAT_W-1:0] win_q;
  logic [CNT_W-1:0] fill_q;

  assign next_win_o = {win_q[PAT_W-2:0], bit_i};
  assign fill_o     = fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      if (shift_en) win_q <= next_win_o;
      if (clear_fill) fill_q <= '0;
      else if (shift_en && fill_q != CNT_W'(PAT_W)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdet_mismatch.sv
`timescale 1ns/1ps
module sdet_mismatch #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int CNT_W     = 6,
  localparam int PAT_W    = BYTE_W * NUM_BYTES,
  localparam int LSEL_W   = $clog2(NUM_BYTES),
  localparam int SH_W     = $clog2(PAT_W)
) (
  input  logic [PAT_W-1:0]  win_i,
  input  logic [PAT_W-1:0]  pattern_i,
  input  logic [LSEL_W-1:0] len_sel_i,
  output logic [CNT_W-1:0]  miss_o
);
  localparam logic [LSEL_W-1:0] LANE_MAX = LSEL_W'(NUM_BYTES - 1);

  logic [PAT_W-1:0] mask, aligned, diff;
  logic [SH_W-1:0]  shamt;

  // lane j holds window bits [j*BYTE_W +: BYTE_W], lane 0 most recent
  for (genvar j = 0; j < NUM_BYTES; j++) begin : g_lane
    assign mask[j*BYTE_W +: BYTE_W] =
      (LSEL_W'(j) <= len_sel_i) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
  end

  // leading pattern bytes are moved down to line up with the newest bits
  always_comb begin
    shamt   = SH_W'(BYTE_W) * SH_W'(LANE_MAX - len_sel_i);
    aligned = pattern_i >> shamt;
    diff    = (win_i ^ aligned) & mask;
  end

  always_comb begin
    miss_o = '0;
    for (int i = 0; i < PAT_W; i++) miss_o = miss_o + CNT_W'(diff[i]);
  end
endmodule

// File: rtl/sync_word_detector.sv
`timescale 1ns/1ps
module sync_word_detector #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int TOL_W     = 2,
  localparam int PAT_W    = BYTE_W * NUM_BYTES,
  localparam int LSEL_W   = $clog2(NUM_BYTES),
  localparam int CNT_W    = $clog2(PAT_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitclk_en,
  input  logic              det_en,
  input  logic              sdata,
  input  logic [LSEL_W-1:0] len_sel,
  input  logic [TOL_W-1:0]  tol_sel,
  input  logic [PAT_W-1:0]  pattern,
  output logic              det_o
);
  logic             active, fire;
  logic [PAT_W-1:0] next_win;
  logic [CNT_W-1:0] fill, miss, need;

  assign active = bitclk_en & det_en;

  sdet_window #(.PAT_W(PAT_W), .CNT_W(CNT_W)) win_i (
    .clk(clk), .rst(rst), .shift_en(active), .clear_fill(!active || fire),
    .bit_i(sdata), .next_win_o(next_win), .fill_o(fill)
  );

  sdet_mismatch #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W)) cmp_i (
    .win_i(next_win), .pattern_i(pattern), .len_sel_i(len_sel), .miss_o(miss)
  );

  always_comb begin
    need = CNT_W'(sdet_pkg::active_bits(int'(len_sel), BYTE_W));
    fire = active && ((fill + 1'b1) >= need) && (miss <= CNT_W'(tol_sel));
  end

  always_ff @(posedge clk) begin
    if (rst) det_o <= 1'b0;
    else     det_o <= fire;
  end
endmodule

// File: rtl/sdet_checker.sv
`timescale 1ns/1ps
module sdet_checker #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int TOL_W     = 2,
  localparam int PAT_W    = BYTE_W * NUM_BYTES,
  localparam int LSEL_W   = $clog2(NUM_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              bitclk_en,
  input logic              det_en,
  input logic              sdata,
  input logic [LSEL_W-1:0] len_sel,
  input logic [TOL_W-1:0]  tol_sel,
  input logic [PAT_W-1:0]  pattern,
  input logic              det_o
);
  logic             act;
  logic [PAT_W-1:0] hist, hist_nx;
  int               gap, gap_inc, need_c;
  logic             ok_q, tol0_q, exact_q, exact_c;

  assign act     = bitclk_en && det_en;
  assign hist_nx = {hist[PAT_W-2:0], sdata};

  always_comb begin
    need_c  = (int'(len_sel) + 1) * BYTE_W;
    gap_inc = det_o ? 1 : gap + 1;
    exact_c = 1'b1;
    for (int i = 0; i < PAT_W; i++) begin
      if (i < need_c) begin
        if (hist_nx[i] != pattern[PAT_W - need_c + i]) exact_c = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0; gap <= 0; ok_q <= 1'b0; tol0_q <= 1'b0; exact_q <= 1'b0;
    end else begin
      if (act) hist <= hist_nx;
      gap     <= act ? ((gap_inc > PAT_W) ? PAT_W : gap_inc) : 0;
      ok_q    <= act && (gap_inc >= need_c);
      tol0_q  <= (tol_sel == '0);
      exact_q <= exact_c;
    end
  end

  // R6: single clock wide pulse
  a_r6_one_wide: assert property (@(posedge clk) disable iff (rst) det_o |=> !det_o);
  // R7: no detect following an inactive edge
  a_r7_needs_enables: assert property (@(posedge clk) disable iff (rst)
    !(det_en && bitclk_en) |=> !det_o);
  // R8 / R9: enough fresh bits before any detect
  a_r8_rearm_gap: assert property (@(posedge clk) disable iff (rst) det_o |-> ok_q);
  // R3: with zero tolerance the aligned window equals the pattern
  a_r3_exact_zero_tol: assert property (@(posedge clk) disable iff (rst)
    (det_o && tol0_q) |-> exact_q);
endmodule

bind sync_word_detector sdet_checker #(
  .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .TOL_W(TOL_W)
) chk_i (
  .clk(clk), .rst(rst), .bitclk_en(bitclk_en), .det_en(det_en), .sdata(sdata),
  .len_sel(len_sel), .tol_sel(tol_sel), .pattern(pattern), .det_o(det_o)
);

// File: tb/sync_word_detector_tb.sv
`timescale 1ns/1ps
module sync_word_detector_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, bitclk_en, det_en, sdata, det;
  logic [1:0]  len_sel, tol_sel;
  logic [31:0] pattern;

  sync_word_detector dut_i (
    .clk(clk), .rst(rst), .bitclk_en(bitclk_en), .det_en(det_en), .sdata(sdata),
    .len_sel(len_sel), .tol_sel(tol_sel), .pattern(pattern), .det_o(det)
  );

  int total = 0, bad = 0;
  logic [31:0] m_hist;
  int          m_fill;
  logic        m_exp;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s det=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int popc(input logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // one clock: drive, model at the edge, compare after it (R2)
  task automatic step(input logic b);
    int n;
    logic [31:0] msk, al;
    sdata = b;
    @(posedge clk);
    n = (int'(len_sel) + 1) * 8;
    if (rst) begin
      m_hist = '0; m_fill = 0; m_exp = 1'b0;
    end else if (!(det_en && bitclk_en)) begin
      m_fill = 0; m_exp = 1'b0;
    end else begin
      m_hist = {m_hist[30:0], b};
      msk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
      al  = pattern >> (32 - n);
      m_exp = (m_fill + 1 >= n) && (popc((m_hist ^ al) & msk) <= int'(tol_sel));
      m_fill = m_exp ? 0 : ((m_fill + 1 > 63) ? 63 : m_fill + 1);
    end
    @(negedge clk);
    check("R2", det, m_exp);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(1'b0); rst = 1'b0;
    check("R1", det, 1'b0);
  endtask

  // send pattern bits first..last, flipping k odd-indexed bits
  task automatic send_pat(input int k, input bit rev);
    int n = (int'(len_sel) + 1) * 8;
    for (int i = 0; i < n; i++) begin
      logic b = rev ? pattern[32 - n + i] : pattern[31 - i];
      if ((i % 2 == 1) && (i / 2 < k)) b = ~b;
      step(b);
    end
  endtask

  task automatic idle_one();
    det_en = 1'b0; step(rnd()); check("R7", det, 1'b0); det_en = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bitclk_en = 1'b1; det_en = 1'b1; sdata = 1'b0;
    len_sel = 2'd0; tol_sel = 2'd0; pattern = 32'hB2D4_1E67;
    m_hist = '0; m_fill = 0; m_exp = 1'b0;
    @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      for (int t = 0; t < 4; t++) begin
        len_sel = 2'(l); tol_sel = 2'(t);
        do_reset();
        repeat (40) step(rnd());
        for (int k = 0; k <= 4; k++) begin
          idle_one();
          send_pat(k, 1'b0);
          if (k == 0) check("R3", det, 1'b1);
          else if (k <= t) check("R4", det, 1'b1);
          else check("R5", det, 1'b0);
          step(rnd());
          check("R6", det, 1'b0);
        end
        // back-to-back repeat
        idle_one();
        send_pat(0, 1'b0); check("R8", det, 1'b1);
        send_pat(0, 1'b0); check("R8", det, 1'b1);
        // pattern cut by a bit clock gap
        idle_one();
        for (int i = 0; i < (l + 1) * 4; i++) step(pattern[31 - i]);
        bitclk_en = 1'b0; step(1'b0); check("R7", det, 1'b0); bitclk_en = 1'b1;
        for (int i = (l + 1) * 4; i < (l + 1) * 8; i++) step(pattern[31 - i]);
        check("R9", det, 1'b0);
        // full pattern after re-enable
        send_pat(0, 1'b0); check("R9", det, 1'b1);
        // reversed bit order, model decides
        idle_one();
        send_pat(0, 1'b1);
        repeat (20) step(rnd());
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule